// File: doc/BRIEF.md
# Thresholded Event Occurrence Counter

This block is one performance-monitoring counter. Every cycle it receives a small vector of per-source event increments. Each element is the number of events that a pipeline stage up to four lanes wide produced in that cycle. A configuration register picks one source through an event selector code and a qualifier mask. The counter then runs in one of two modes. In summing mode it adds the selected increment to a wide running total. In threshold mode it adds one for each cycle whose increment passes a comparison against a programmable threshold.

Setting the threshold to 1 and setting the invert bit makes the counter count cycles in which the selected source produced nothing. These are stall cycles. A threshold N with invert clear counts cycles with at least N events. With invert set it counts cycles with fewer than N events. One counter can therefore measure either throughput or idle time. The running total wraps silently, and a sticky flag records that a wrap happened. All pins are plain control and status levels. There is no handshake, and the block accepts an event vector in every clock cycle.

Top module: `thr_evt_counter`

## Requirements
- R1: With threshold 0 (summing mode), each enabled cycle adds the selected source's increment, 0 to 4, to the total.
- R2: Source k (k below NUM_SRC) is selected when the selector code equals 0x20 plus k and the qualifier mask equals 0x01. Source k's increment occupies bits [3k+2:3k] of the event vector.
- R3: A selector code and qualifier mask pair that matches no source contributes zero in summing mode.
- R4: With a threshold N greater than 0 and invert clear, an enabled cycle adds 1 when the selected increment is at least N, and adds 0 otherwise.
- R5: With a threshold N greater than 0 and invert set, an enabled cycle adds 1 when the selected increment is below N. N equal to 1 counts cycles with zero events.
- R6: The invert bit has no effect in summing mode.
- R7: An increment input above 4 is treated as 4.
- R8: While the enable is low, the total does not change.
- R9: A configuration write is captured when the write strobe is high. The cycle of the write still counts under the previous configuration, and the new one applies from the next cycle.
- R10: The total is CNT_W bits wide and wraps modulo 2^CNT_W. A wrap sets a sticky overflow flag that holds until a configuration write or a reset.
- R11: Reset clears the total and the overflow flag. It also loads a configuration that matches no source, with threshold 0 and invert clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counting enable for the current cycle |
| evt_inc | input | NUM_SRC*3 | Packed per-source event increments, source k at bits [3k+2:3k] |
| cfg_wr | input | 1 | Configuration write strobe; also clears the overflow flag |
| cfg_code | input | 8 | Event selector code to be written |
| cfg_umask | input | 8 | Qualifier mask to be written |
| cfg_cmask | input | 8 | Threshold to be written; 0 selects summing mode |
| cfg_inv | input | 1 | Invert bit to be written |
| count_q | output | CNT_W | Running total |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
Some rules are checked on every cycle. The total holds whenever the enable is low. The flag stays set until a write clears it, and it can only rise on a cycle where the total went down. Threshold mode never steps by more than one. The clamped increment never exceeds four, and an unmatched selection contributes nothing in summing mode. Only the bench scenarios can show the exact step values: the source decoding, the comparison direction for each threshold and invert setting, the one-cycle delay before a new configuration applies, and the exact wrapped value at overflow.

// File: rtl/thr_evt_pkg.sv
`timescale 1ns/1ps
package thr_evt_pkg;

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] umask;
    logic [7:0] cmask;
    logic       inv;
  } evt_cfg_t;

  localparam logic [7:0] SRC_CODE_BASE = 8'h20;
  localparam logic [7:0] SRC_UMASK     = 8'h01;
  localparam evt_cfg_t   CFG_RESET     = '{code: 8'h00, umask: 8'h00, cmask: 8'h00, inv: 1'b0};

endpackage

// File: rtl/thr_evt_sel.sv
`timescale 1ns/1ps
module thr_evt_sel
  import thr_evt_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int INC_MAX = 4,
  parameter int EVT_W   = $clog2(INC_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC*EVT_W-1:0] evt_inc,
  input  logic [7:0]               sel_code,
  input  logic [7:0]               sel_umask,
  output logic [EVT_W-1:0]         sel_cnt,
  output logic                     sel_hit
);

  localparam logic [EVT_W-1:0] MAX_V = EVT_W'(INC_MAX);

  logic [NUM_SRC-1:0] match;
  logic [EVT_W-1:0]   clamp [NUM_SRC];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [EVT_W-1:0] raw;
    assign raw      = evt_inc[k*EVT_W +: EVT_W];
    assign clamp[k] = (raw > MAX_V) ? MAX_V : raw;
    assign match[k] = (sel_code == (SRC_CODE_BASE + 8'(k))) && (sel_umask == SRC_UMASK);
  end

  always_comb begin
    sel_cnt = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (match[k]) sel_cnt = sel_cnt | clamp[k];
    end
  end

  assign sel_hit = |match;

  // R7
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt <= MAX_V);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/thr_evt_qual.sv
`timescale 1ns/1ps
module thr_evt_qual #(
  parameter int EVT_W = 3
) (
  input  logic [EVT_W-1:0] sel_cnt,
  input  logic [7:0]       cmask,
  input  logic             inv,
  output logic [EVT_W-1:0] step
);

  logic [7:0] cnt_ext;
  logic       meets;
  logic       pass;

  assign cnt_ext = 8'(sel_cnt);
  assign meets   = (cnt_ext >= cmask);
  assign pass    = meets ^ inv;

  always_comb begin
    if (cmask == 8'd0) step = sel_cnt;
    else               step = EVT_W'(pass);
  end

endmodule

// File: rtl/thr_evt_acc.sv
`timescale 1ns/1ps
module thr_evt_acc #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [EVT_W-1:0] step,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q
);

  logic [CNT_W:0] sum;

  assign sum = {1'b0, count_q} + (CNT_W+1)'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (en) count_q <= sum[CNT_W-1:0];
      if (en && sum[CNT_W]) ovf_q <= 1'b1;
      else if (clr_ovf)     ovf_q <= 1'b0;
    end
  end

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count_q));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);

  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (count_q < $past(count_q)));

endmodule

// File: rtl/thr_evt_counter.sv
`timescale 1ns/1ps
module thr_evt_counter
  import thr_evt_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int INC_MAX = 4,
  parameter int CNT_W   = 48
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      count_en,
  input  logic [NUM_SRC*$clog2(INC_MAX+1)-1:0]      evt_inc,
  input  logic                                      cfg_wr,
  input  logic [7:0]                                cfg_code,
  input  logic [7:0]                                cfg_umask,
  input  logic [7:0]                                cfg_cmask,
  input  logic                                      cfg_inv,
  output logic [CNT_W-1:0]                          count_q,
  output logic                                      ovf_q
);

  localparam int EVT_W = $clog2(INC_MAX + 1);

  evt_cfg_t         cfg_q;
  logic [EVT_W-1:0] sel_cnt;
  logic             sel_hit;
  logic [EVT_W-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_wr) cfg_q <= '{code: cfg_code, umask: cfg_umask, cmask: cfg_cmask, inv: cfg_inv};
  end

  thr_evt_sel #(.NUM_SRC(NUM_SRC), .INC_MAX(INC_MAX), .EVT_W(EVT_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_inc   (evt_inc),
    .sel_code  (cfg_q.code),
    .sel_umask (cfg_q.umask),
    .sel_cnt   (sel_cnt),
    .sel_hit   (sel_hit)
  );

  thr_evt_qual #(.EVT_W(EVT_W)) u_qual (
    .sel_cnt (sel_cnt),
    .cmask   (cfg_q.cmask),
    .inv     (cfg_q.inv),
    .step    (step)
  );

  thr_evt_acc #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (count_en),
    .step    (step),
    .clr_ovf (cfg_wr),
    .count_q (count_q),
    .ovf_q   (ovf_q)
  );

  // R4 and R5: threshold mode never steps by more than one
  thr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.cmask != 8'd0) |-> (step <= EVT_W'(1)));

  // R3
  nomatch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_hit && cfg_q.cmask == 8'd0) |-> (step == '0));

endmodule

// File: tb/thr_evt_counter_tb_top.sv
`timescale 1ns/1ps
module thr_evt_counter_tb_top;

  localparam int TB_CW = 10;
  localparam int NV    = 15;
  localparam longint WRAP = 1024;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              count_en;
  logic [11:0]       evt_inc;
  logic              cfg_wr;
  logic [7:0]        cfg_code, cfg_umask, cfg_cmask;
  logic              cfg_inv;
  logic [TB_CW-1:0]  count_q;
  logic              ovf_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  longint exp_cnt;

  always #2.5 clk = ~clk;

  thr_evt_counter #(.NUM_SRC(4), .INC_MAX(4), .CNT_W(TB_CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .evt_inc(evt_inc),
    .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_umask(cfg_umask),
    .cfg_cmask(cfg_cmask), .cfg_inv(cfg_inv), .count_q(count_q), .ovf_q(ovf_q)
  );

  // {code, umask, cmask, inv, src3, src2, src1, src0, expected step}
  localparam logic [40:0] VEC [NV] = '{
    {8'h20, 8'h01, 8'd0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd3, 4'd3},
    {8'h21, 8'h01, 8'd0, 1'b0, 3'd1, 3'd2, 3'd4, 3'd3, 4'd4},
    {8'h22, 8'h01, 8'd1, 1'b1, 3'd1, 3'd0, 3'd4, 3'd3, 4'd1},
    {8'h22, 8'h01, 8'd1, 1'b1, 3'd0, 3'd2, 3'd0, 3'd0, 4'd0},
    {8'h23, 8'h01, 8'd2, 1'b0, 3'd2, 3'd0, 3'd0, 3'd0, 4'd1},
    {8'h23, 8'h01, 8'd2, 1'b0, 3'd1, 3'd4, 3'd4, 3'd4, 4'd0},
    {8'h20, 8'h01, 8'd3, 1'b1, 3'd4, 3'd4, 3'd4, 3'd2, 4'd1},
    {8'h20, 8'h01, 8'd3, 1'b1, 3'd0, 3'd0, 3'd0, 3'd3, 4'd0},
    {8'h20, 8'h01, 8'd1, 1'b0, 3'd0, 3'd0, 3'd0, 3'd1, 4'd1},
    {8'h24, 8'h01, 8'd0, 1'b0, 3'd4, 3'd4, 3'd4, 3'd4, 4'd0},
    {8'h20, 8'h02, 8'd0, 1'b0, 3'd4, 3'd4, 3'd4, 3'd3, 4'd0},
    {8'h21, 8'h01, 8'd0, 1'b0, 3'd0, 3'd0, 3'd7, 3'd0, 4'd4},
    {8'h20, 8'h01, 8'd0, 1'b1, 3'd0, 3'd0, 3'd0, 3'd2, 4'd2},
    {8'h21, 8'h01, 8'd5, 1'b0, 3'd0, 3'd0, 3'd4, 3'd0, 4'd0},
    {8'h21, 8'h01, 8'd5, 1'b1, 3'd0, 3'd0, 3'd4, 3'd0, 4'd1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:   return "R1";
      2, 3:   return "R5";
      4, 5:   return "R4";
      6, 7:   return "R5";
      8:      return "R4";
      9:      return "R3";
      10:     return "R2";
      11:     return "R7";
      12:     return "R6";
      13:     return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] c, logic [7:0] u, logic [7:0] m, logic i, logic en,
                           logic [11:0] ev);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_code = c; cfg_umask = u; cfg_cmask = m; cfg_inv = i;
    count_en = en; evt_inc = ev;
  endtask

  task automatic run_cycle(logic en, logic [11:0] ev);
    @(negedge clk);
    cfg_wr = 1'b0; count_en = en; evt_inc = ev;
  endtask

  initial begin
    rst_n = 1'b0; count_en = 1'b0; evt_inc = '0; cfg_wr = 1'b0;
    cfg_code = '0; cfg_umask = '0; cfg_cmask = '0; cfg_inv = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 count", count_q, 0);
    check("R11 ovf", ovf_q, 0);
    rst_n = 1'b1;
    // reset configuration matches no source: all-4 events add nothing
    run_cycle(1'b1, {3'd4, 3'd4, 3'd4, 3'd4});
    @(negedge clk); count_en = 1'b0;
    check("R11 reset cfg", count_q, 0);
    exp_cnt = 0;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      write_cfg(v[40:33], v[32:25], v[24:17], v[16], 1'b0, '0);
      run_cycle(1'b1, v[15:4]);
      @(negedge clk); count_en = 1'b0; evt_inc = '0;
      exp_cnt += longint'(v[3:0]);
      check(vec_tag(i), count_q, exp_cnt);
    end

    // R8: enable low holds the total
    write_cfg(8'h20, 8'h01, 8'd0, 1'b0, 1'b0, '0);
    run_cycle(1'b0, {3'd4, 3'd4, 3'd4, 3'd4});
    run_cycle(1'b0, {3'd4, 3'd4, 3'd4, 3'd4});
    @(negedge clk);
    check("R8 hold", count_q, exp_cnt);

    // R9: write cycle counts under old config (raw src0), next under new (raw src1)
    write_cfg(8'h21, 8'h01, 8'd0, 1'b0, 1'b1, {3'd0, 3'd0, 3'd4, 3'd3});
    run_cycle(1'b1, {3'd0, 3'd0, 3'd4, 3'd3});
    exp_cnt += 3;
    check("R9 old cfg", count_q, exp_cnt);
    @(negedge clk); count_en = 1'b0;
    exp_cnt += 4;
    check("R9 new cfg", count_q, exp_cnt);

    // R10: wrap and sticky overflow
    while (exp_cnt + 4 < WRAP) begin
      run_cycle(1'b1, {3'd0, 3'd0, 3'd4, 3'd0});
      exp_cnt += 4;
    end
    @(negedge clk); count_en = 1'b0;
    check("R10 pre-wrap count", count_q, exp_cnt);
    check("R10 pre-wrap ovf", ovf_q, 0);
    run_cycle(1'b1, {3'd0, 3'd0, 3'd4, 3'd0});
    @(negedge clk); count_en = 1'b0;
    exp_cnt = exp_cnt + 4 - WRAP;
    check("R10 wrapped count", count_q, exp_cnt);
    check("R10 ovf set", ovf_q, 1);
    repeat (2) @(negedge clk);
    check("R10 ovf sticky", ovf_q, 1);
    write_cfg(8'h21, 8'h01, 8'd0, 1'b0, 1'b0, '0);
    @(negedge clk); cfg_wr = 1'b0;
    check("R10 ovf cleared", ovf_q, 0);
    check("R10 count kept", count_q, exp_cnt);

    // R11: reset mid-run
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 count after reset", count_q, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule